// File: doc/BRIEF.md
# Configurable Serial Frame Monitor

This block listens passively to one asynchronous serial line and rebuilds each character frame on it. The line rests high. A frame opens with a falling edge. After that the block reads the line once in the middle of every bit slot, timing each slot from the cycle in which the edge was seen. The bit period is an integer number of clocks taken from an input. The frame format is chosen at run time: the data word length, the bit order and one of five parity modes. The block does not drive the line.

Each completed frame appears on the outputs as a data word with a one-cycle valid strobe. Three error flags go with the word: a start bit that was not low at its centre, a parity mismatch, and a stop bit that was low. The word and the flags stay on the outputs until the next frame completes. The format inputs are captured when a frame opens, so changing them in the middle of a frame does not affect that frame.

Top module: `uart_frame_monitor`

## Requirements
- R1: After reset, valid_o, start_err_o, parity_err_o and stop_err_o are 0, data_o is all zeros, and the monitor waits for a falling edge.
- R2: The serial input passes through two flip-flops before edge detection. A frame opens in the cycle where the synchronized line is 0 and was 1 in the cycle before. That cycle counts as elapsed time 0.
- R3: Bit slot k (slot 0 = start, slots 1..N = data, then parity if enabled, then stop) is read at elapsed time (clks_per_bit_i >> 1) + k * clks_per_bit_i. The value of clks_per_bit_i must be at least 2.
- R4: data_bits_i selects the word length N. Codes 5 to 9 give that many bits, codes below 5 give 5, and codes above 9 give 9.
- R5: With msb_first_i = 0, the first data bit received lands in data_o bit 0. With msb_first_i = 1, the first data bit lands in bit N-1. Bits of data_o at N and above are 0.
- R6: parity_mode_i = 1 (odd) reports no error when the data bits plus the parity bit hold an odd number of ones. parity_mode_i = 2 (even) reports no error when that count is even. Otherwise parity_err_o is set.
- R7: parity_mode_i = 3 expects a parity bit of 0 and parity_mode_i = 4 expects a parity bit of 1. Any other parity bit sets parity_err_o.
- R8: parity_mode_i = 0 and codes 5 to 7 mean no parity. The stop slot comes directly after the last data bit, and parity_err_o is 0.
- R9: If the start slot reads 1, start_err_o is set for that frame, and the data, parity and stop slots are still read at their normal times.
- R10: A stop slot that reads 0 sets stop_err_o. After the stop slot the monitor waits for a new edge, which it can detect in the very next cycle.
- R11: valid_o is high for exactly the one cycle after the stop-slot cycle. In that same cycle data_o and the three flags take the frame's values, and they stay unchanged until the next valid_o.
- R12: clks_per_bit_i, data_bits_i, msb_first_i and parity_mode_i are captured in the frame-opening cycle. Later changes to them do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Asynchronous serial line, idle high |
| clks_per_bit_i | input | CPB_W | Bit period in clocks (at least 2) |
| data_bits_i | input | $clog2(MAX_DATA+1) | Data word length code |
| msb_first_i | input | 1 | 1 = most significant bit sent first |
| parity_mode_i | input | 3 | 0 none, 1 odd, 2 even, 3 zero, 4 one, 5-7 none |
| data_o | output | MAX_DATA | Assembled data word |
| valid_o | output | 1 | One-cycle strobe for a completed frame |
| start_err_o | output | 1 | Start slot read high |
| parity_err_o | output | 1 | Parity check failed |
| stop_err_o | output | 1 | Stop slot read low |

## Verification
The bench drives frames at odd, minimum and large bit periods. At these settings a slip in the half-period rounding, or one cycle too many or too few in the synchronizer, moves the slot reads onto bit edges and shifts the valid strobe, and the per-cycle comparison catches this. It also covers the word-length clamps, both bit orders at 5 and 9 bits, and each parity mode with a correct and a flipped parity bit. A design that reversed the insertion point, or counted the parity bit on the wrong side, would produce wrong words or flags. A glitched start bit checks that the frame still completes with the flag set rather than being aborted. A frame started immediately after a low stop bit shows whether the return to waiting loses an edge. Changing the format inputs mid-frame exposes any design that reads them live rather than capturing them.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

   typedef enum logic [2:0] {
      PM_NONE  = 3'd0,
      PM_ODD   = 3'd1,
      PM_EVEN  = 3'd2,
      PM_SPACE = 3'd3,
      PM_MARK  = 3'd4
   } pmode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } st_e;

   function automatic pmode_e decode_pmode(input logic [2:0] code);
      if (code > 3'd4) begin
         return PM_NONE;
      end
      return pmode_e'(code);
   endfunction

endpackage

// File: rtl/uart_mon_sync.sv
module uart_mon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic samp_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_mon_sync: STAGES must be at least 2");
      end
   endgenerate

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= line_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign samp_o = chain_q[STAGES-1];
   assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/uart_mon_timer.sv
module uart_mon_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic [CNT_W-1:0] arm_val_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] period_m1_i,
   output logic             fire_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (arm_i) begin
         cnt_q <= arm_val_i;
      end else if (run_i) begin
         if (cnt_q == '0) cnt_q <= period_m1_i;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign fire_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/uart_mon_shift.sv
module uart_mon_shift #(
   parameter int DW   = 9,
   parameter int NB_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic            en_i,
   input  logic            bit_i,
   input  logic            msb_first_i,
   input  logic [NB_W-1:0] nbits_i,
   output logic [DW-1:0]   word_o
);

   logic [DW-1:0] word_q;
   logic [DW-1:0] lsb_nxt;
   logic [DW-1:0] msb_nxt;

   always_comb begin
      lsb_nxt = word_q >> 1;
      for (int i = 0; i < DW; i++) begin
         if (i == int'(nbits_i) - 1) lsb_nxt[i] = bit_i;
      end
      msb_nxt = {word_q[DW-2:0], bit_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (clear_i) begin
         word_q <= '0;
      end else if (en_i) begin
         word_q <= msb_first_i ? msb_nxt : lsb_nxt;
      end
   end

   assign word_o = word_q;

endmodule

// File: rtl/uart_mon_parity.sv
module uart_mon_parity #(
   parameter int DW = 9
) (
   input  logic [DW-1:0]           word_i,
   input  logic                    pbit_i,
   input  uart_mon_pkg::pmode_e    mode_i,
   output logic                    ok_o
);

   import uart_mon_pkg::*;

   logic odd_total;

   assign odd_total = (^word_i) ^ pbit_i;

   always_comb begin
      case (mode_i)
         PM_ODD:   ok_o = odd_total;
         PM_EVEN:  ok_o = ~odd_total;
         PM_SPACE: ok_o = ~pbit_i;
         PM_MARK:  ok_o = pbit_i;
         default:  ok_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/uart_frame_monitor.sv
module uart_frame_monitor
   import uart_mon_pkg::*;
#(
   parameter  int CPB_W       = 16,
   parameter  int MAX_DATA    = 9,
   parameter  int SYNC_STAGES = 2,
   localparam int NB_W        = $clog2(MAX_DATA + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_i,
   input  logic [CPB_W-1:0]    clks_per_bit_i,
   input  logic [NB_W-1:0]     data_bits_i,
   input  logic                msb_first_i,
   input  logic [2:0]          parity_mode_i,
   output logic [MAX_DATA-1:0] data_o,
   output logic                valid_o,
   output logic                start_err_o,
   output logic                parity_err_o,
   output logic                stop_err_o
);

   localparam int MIN_DATA = 5;

   generate
      if (MAX_DATA < MIN_DATA) begin : g_bad_width
         $error("uart_frame_monitor: MAX_DATA must be at least 5");
      end
      if (CPB_W < 2) begin : g_bad_cpb
         $error("uart_frame_monitor: CPB_W must be at least 2");
      end
   endgenerate

   logic                samp;
   logic                fall;
   st_e                 state_q;
   logic [CPB_W-1:0]    cpb_q;
   logic [NB_W-1:0]     nb_q;
   logic                msb_q;
   pmode_e              pm_q;
   logic [NB_W-1:0]     idx_q;
   logic                serr_q;
   logic                pbit_q;
   logic [NB_W-1:0]     nb_eff;
   logic                arm;
   logic                run;
   logic                fire;
   logic [CPB_W-1:0]    arm_val;
   logic [CPB_W-1:0]    period_m1;
   logic [MAX_DATA-1:0] word;
   logic                par_ok;
   logic                shift_en;

   uart_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_i),
      .samp_o (samp),
      .fall_o (fall)
   );

   always_comb begin
      if (data_bits_i < NB_W'(MIN_DATA))      nb_eff = NB_W'(MIN_DATA);
      else if (data_bits_i > NB_W'(MAX_DATA)) nb_eff = NB_W'(MAX_DATA);
      else                                    nb_eff = data_bits_i;
   end

   assign arm       = (state_q == ST_IDLE) && fall;
   assign run       = (state_q != ST_IDLE);
   assign arm_val   = (clks_per_bit_i >> 1) - CPB_W'(1);
   assign period_m1 = cpb_q - CPB_W'(1);
   assign shift_en  = (state_q == ST_DATA) && fire;

   uart_mon_timer #(.CNT_W(CPB_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm),
      .arm_val_i   (arm_val),
      .run_i       (run),
      .period_m1_i (period_m1),
      .fire_o      (fire)
   );

   uart_mon_shift #(.DW(MAX_DATA), .NB_W(NB_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (arm),
      .en_i        (shift_en),
      .bit_i       (samp),
      .msb_first_i (msb_q),
      .nbits_i     (nb_q),
      .word_o      (word)
   );

   uart_mon_parity #(.DW(MAX_DATA)) u_parity (
      .word_i (word),
      .pbit_i (pbit_q),
      .mode_i (pm_q),
      .ok_o   (par_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cpb_q        <= CPB_W'(2);
         nb_q         <= NB_W'(MIN_DATA);
         msb_q        <= 1'b0;
         pm_q         <= PM_NONE;
         idx_q        <= '0;
         serr_q       <= 1'b0;
         pbit_q       <= 1'b0;
         data_o       <= '0;
         valid_o      <= 1'b0;
         start_err_o  <= 1'b0;
         parity_err_o <= 1'b0;
         stop_err_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (fall) begin
                  state_q <= ST_START;
                  cpb_q   <= clks_per_bit_i;
                  nb_q    <= nb_eff;
                  msb_q   <= msb_first_i;
                  pm_q    <= decode_pmode(parity_mode_i);
                  idx_q   <= '0;
               end
            end
            ST_START: begin
               if (fire) begin
                  serr_q  <= samp;
                  state_q <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (fire) begin
                  idx_q <= idx_q + 1'b1;
                  if (idx_q == nb_q - 1'b1) begin
                     state_q <= (pm_q == PM_NONE) ? ST_STOP : ST_PAR;
                  end
               end
            end
            ST_PAR: begin
               if (fire) begin
                  pbit_q  <= samp;
                  state_q <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (fire) begin
                  data_o       <= word;
                  start_err_o  <= serr_q;
                  parity_err_o <= ~par_ok;
                  stop_err_o   <= ~samp;
                  valid_o      <= 1'b1;
                  state_q      <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uart_mon_chk.sv
module uart_mon_chk
   import uart_mon_pkg::*;
#(
   parameter int DW    = 9,
   parameter int CFG_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid_o,
   input logic [DW-1:0]    data_o,
   input logic             start_err_o,
   input logic             parity_err_o,
   input logic             stop_err_o,
   input st_e              state_i,
   input logic             fall_i,
   input pmode_e           pm_i,
   input logic [CFG_W-1:0] cfg_i
);

   // R11
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R11
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(data_o));

   // R11
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(start_err_o) && $stable(parity_err_o) && $stable(stop_err_o)));

   // R11
   valid_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ($past(state_i) == ST_STOP));

   // R2
   edge_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_IDLE && fall_i) |=> (state_i == ST_START));

   // R8
   no_parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && pm_i == PM_NONE) |-> !parity_err_o);

   // R12
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i != ST_IDLE && $past(state_i) != ST_IDLE) |-> $stable(cfg_i));

endmodule

bind uart_frame_monitor uart_mon_chk #(
   .DW    (MAX_DATA),
   .CFG_W (CPB_W + NB_W + 4)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .valid_o      (valid_o),
   .data_o       (data_o),
   .start_err_o  (start_err_o),
   .parity_err_o (parity_err_o),
   .stop_err_o   (stop_err_o),
   .state_i      (state_q),
   .fall_i       (fall),
   .pm_i         (pm_q),
   .cfg_i        ({cpb_q, nb_q, msb_q, pm_q})
);

// File: tb/uart_frame_monitor_test.sv
module uart_frame_monitor_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line = 1'b1;
   logic [15:0] cpb_in = 16'd8;
   logic [3:0] nb_in = 4'd8;
   logic       msb_in = 1'b0;
   logic [2:0] pm_in = 3'd0;
   logic [8:0] data_o;
   logic       valid_o, start_err_o, parity_err_o, stop_err_o;

   int    checks = 0;
   int    errors = 0;
   string cur_tag = "R1";

   always #10 clk = ~clk;

   uart_frame_monitor uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .line_i         (line),
      .clks_per_bit_i (cpb_in),
      .data_bits_i    (nb_in),
      .msb_first_i    (msb_in),
      .parity_mode_i  (pm_in),
      .data_o         (data_o),
      .valid_o        (valid_o),
      .start_err_o    (start_err_o),
      .parity_err_o   (parity_err_o),
      .stop_err_o     (stop_err_o)
   );

   task automatic fail(input string tag, input string what, input int act, input int exp);
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
   endtask

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) fail(tag, what, act, exp);
   endtask

   // reference model
   bit m_s1, m_samp, m_prev, m_busy, m_msb, m_serr, m_pbit;
   int m_el, m_k, m_cpb, m_nb, m_pm, m_word;
   bit e_valid, e_serr, e_perr, e_stop;
   int e_data;
   bit m_run = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 1; m_samp = 1; m_prev = 1; m_busy = 0;
         e_valid = 0; e_serr = 0; e_perr = 0; e_stop = 0; e_data = 0;
         m_pbit = 0; m_serr = 0;
      end else begin
         e_valid = 0;
         if (!m_busy) begin
            if (m_prev && !m_samp) begin
               m_busy = 1; m_el = 0; m_k = 0;
               m_cpb = int'(cpb_in);
               m_nb = (nb_in < 5) ? 5 : ((nb_in > 9) ? 9 : int'(nb_in));
               m_msb = msb_in;
               m_pm = (pm_in > 4) ? 0 : int'(pm_in);
               m_word = 0;
            end
         end else begin
            m_el++;
            if (m_el == m_cpb / 2 + m_k * m_cpb) begin
               if (m_k == 0) begin
                  m_serr = m_samp;
               end else if (m_k <= m_nb) begin
                  if (m_msb) m_word = (m_word << 1) | int'(m_samp);
                  else       m_word = (m_word >> 1) | (int'(m_samp) << (m_nb - 1));
               end else if (m_pm != 0 && m_k == m_nb + 1) begin
                  m_pbit = m_samp;
               end else begin
                  int ones;
                  ones = $countones(m_word) + int'(m_pbit);
                  case (m_pm)
                     1: e_perr = (ones % 2) != 1;
                     2: e_perr = (ones % 2) != 0;
                     3: e_perr = m_pbit != 0;
                     4: e_perr = m_pbit != 1;
                     default: e_perr = 0;
                  endcase
                  e_data = m_word; e_serr = m_serr; e_stop = !m_samp;
                  e_valid = 1; m_busy = 0;
               end
               m_k++;
            end
         end
         m_prev = m_samp; m_samp = m_s1; m_s1 = line;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && m_run) begin
         check(cur_tag, "valid_o", int'(valid_o), int'(e_valid));
         check(cur_tag, "data_o", int'(data_o), e_data);
         check(cur_tag, "start_err_o", int'(start_err_o), int'(e_serr));
         check(cur_tag, "parity_err_o", int'(parity_err_o), int'(e_perr));
         check(cur_tag, "stop_err_o", int'(stop_err_o), int'(e_stop));
      end
   end

   task automatic hold_line(input bit v, input int n);
      line = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input string tag, input int cpb, input int code, input bit msb,
                       input int pm, input int data, input bit flip_par,
                       input bit bad_start, input bit bad_stop, input bit scramble,
                       input int idle);
      int nb;
      int pm_n;
      int ones;
      bit pb;
      cur_tag = tag;
      nb = (code < 5) ? 5 : ((code > 9) ? 9 : code);
      pm_n = (pm > 4) ? 0 : pm;
      cpb_in = 16'(cpb); nb_in = 4'(code); msb_in = msb; pm_in = 3'(pm);
      if (bad_start) begin
         hold_line(1'b0, 1);
         hold_line(1'b1, cpb - 1);
      end else begin
         hold_line(1'b0, cpb);
      end
      if (scramble) begin
         cpb_in = 16'(cpb + 3); nb_in = 4'(14 - code); msb_in = !msb; pm_in = 3'(pm ^ 3);
      end
      ones = 0;
      for (int i = 0; i < nb; i++) begin
         bit b;
         b = msb ? data[nb-1-i] : data[i];
         ones += int'(b);
         hold_line(b, cpb);
      end
      if (pm_n != 0) begin
         case (pm_n)
            1: pb = (ones % 2) == 0;
            2: pb = (ones % 2) == 1;
            3: pb = 0;
            default: pb = 1;
         endcase
         hold_line(pb ^ flip_par, cpb);
      end
      hold_line(!bad_stop, cpb);
      hold_line(1'b1, idle);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      cur_tag = "R1";
      check("R1", "valid_o after reset", int'(valid_o), 0);
      check("R1", "data_o after reset", int'(data_o), 0);
      check("R1", "flags after reset", int'({start_err_o, parity_err_o, stop_err_o}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "valid_o idle", int'(valid_o), 0);
      m_run = 1'b1;
      repeat (5) @(negedge clk);

      send("R5", 8, 8, 0, 0, 'hA5, 0, 0, 0, 0, 16);
      send("R5", 8, 8, 1, 0, 'h3C, 0, 0, 0, 0, 16);
      send("R5", 8, 9, 1, 0, 'h1A7, 0, 0, 0, 0, 16);
      send("R4", 8, 5, 0, 0, 'h15, 0, 0, 0, 0, 16);
      send("R4", 8, 9, 0, 0, 'h1A7, 0, 0, 0, 0, 16);
      send("R4", 8, 3, 1, 0, 'h0B, 0, 0, 0, 0, 16);
      send("R4", 8, 13, 0, 0, 'h155, 0, 0, 0, 0, 16);
      send("R6", 8, 8, 0, 1, 'h5A, 0, 0, 0, 0, 16);
      send("R6", 8, 8, 0, 1, 'h5B, 1, 0, 0, 0, 16);
      send("R6", 8, 7, 1, 2, 'h31, 0, 0, 0, 0, 16);
      send("R6", 8, 7, 1, 2, 'h30, 1, 0, 0, 0, 16);
      send("R7", 8, 8, 0, 3, 'hFF, 0, 0, 0, 0, 16);
      send("R7", 8, 8, 0, 3, 'hFF, 1, 0, 0, 0, 16);
      send("R7", 8, 6, 0, 4, 'h00, 0, 0, 0, 0, 16);
      send("R7", 8, 6, 0, 4, 'h00, 1, 0, 0, 0, 16);
      send("R8", 8, 8, 0, 6, 'h81, 0, 0, 0, 0, 16);
      send("R9", 8, 8, 0, 1, 'h66, 0, 1, 0, 0, 16);
      send("R10", 8, 8, 0, 2, 'h99, 0, 0, 1, 0, 0);
      send("R10", 8, 8, 0, 0, 'h42, 0, 0, 0, 0, 16);
      send("R3", 5, 8, 0, 2, 'hC3, 0, 0, 0, 0, 12);
      send("R3", 2, 9, 1, 1, 'h12D, 0, 0, 0, 0, 8);
      send("R3", 16, 8, 0, 0, 'h7E, 0, 0, 0, 0, 32);
      send("R2", 3, 8, 0, 0, 'h01, 0, 0, 0, 0, 8);
      send("R12", 8, 8, 0, 1, 'hB4, 0, 0, 0, 1, 16);
      send("R12", 6, 5, 1, 4, 'h0D, 0, 0, 0, 1, 16);
      repeat (20) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fail("watchdog", "run did not finish", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule